// File: doc/BRIEF.md
# Dual-Compare Output Pulse Generator

This block is one output-compare channel. It shapes a single output pin from one of two free-running 16-bit up-counters. Each counter counts from zero while its run bit is set. It returns to zero on the clock after it reaches its own period value. A select bit chooses which counter the channel watches.

The channel holds two compare values. When the watched count first reaches the leading value, the pin goes high. When the count first reaches the trailing value, the pin goes low and a sticky interrupt flag is raised. The interrupt output is that flag gated by an enable input.

Two mode codes turn the channel on:
- In the single-pulse code, the pin stays low after one pulse. Writing the mode field again arms another pulse.
- In the repeating code, the pin produces one pulse in every counter period.

Every other code keeps the channel off. Software is expected to program period ≥ trailing value > leading value ≥ 1.

Top module: `dual_match_pulse`

## Requirements
- R1: Mode code 3'b100 selects single-pulse operation and 3'b101 selects repeating operation. Any other code holds `pulse_out` low and never raises `irq_flag`.
- R2: A mode write (`mode_wr` high at a clock edge) takes effect at that edge. After that edge `pulse_out` is low, whatever its earlier level.
- R3: In a pulse mode, the edge after the selected count first equals `cmp_lead` drives `pulse_out` high.
- R4: While the pulse is high, the edge after the selected count first equals `cmp_trail` drives `pulse_out` low. The same edge sets `irq_flag`.
- R5: In single-pulse mode, no further pulse and no further flag follow the trailing edge, even while the counter keeps wrapping.
- R6: Writing 3'b100 again while the counter runs arms a new single pulse. That pulse rises at the next leading match.
- R7: A running counter equal to its period becomes 0 on the next edge. In repeating mode the pulse therefore recurs every period+1 counts.
- R8: `tb_sel` = 0 selects counter A and 1 selects counter B. `tb_run[0]` runs A and `tb_run[1]` runs B. A counter whose run bit is low holds its value.
- R9: A match fires only on the first cycle the count equals a compare value. A count held at the leading value after a mode write raises no pulse.
- R10: `irq_flag` stays set until a cycle with `flag_clr` high, and it reads 0 after that edge.
- R11: `irq` is high exactly when `irq_flag` and `irq_en` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_run | input | 2 | Run bits: bit 0 counter A, bit 1 counter B |
| tb_period_a | input | 16 | Wrap value of counter A |
| tb_period_b | input | 16 | Wrap value of counter B |
| tb_sel | input | 1 | Counter feeding the comparators (0 = A, 1 = B) |
| cmp_lead | input | 16 | Leading-edge compare value |
| cmp_trail | input | 16 | Trailing-edge compare value |
| mode_wr | input | 1 | Mode field write strobe |
| mode_wdata | input | 3 | Mode code written by the strobe |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Clears the interrupt flag |
| pulse_out | output | 1 | Output pin |
| irq_flag | output | 1 | Sticky trailing-match flag |
| irq | output | 1 | Gated interrupt request |
| count_a | output | 16 | Counter A value |
| count_b | output | 16 | Counter B value |

## Verification
A channel stuck in the wrong state shows within one counter period. Examples are a single-pulse channel that re-arms, or a stale match latch. The symptom is an extra or missing high stretch on `pulse_out`, or `irq_flag` rising in a period where it should stay quiet. A match detector that is level-based rather than first-equal appears one cycle after a mode write while the count is held on the leading value. A wrong wrap or selection shows on `count_a` or `count_b`, or as a pulse whose timing does not follow the chosen counter's period.

// File: rtl/dmp_pkg.sv
package dmp_pkg;

    localparam int MODE_W = 3;
    localparam int NUM_TB = 2;
    localparam int NUM_CMP = 2;
    localparam int CMP_LEAD = 0;
    localparam int CMP_TRAIL = 1;

    localparam logic [MODE_W-1:0] MODE_SINGLE = 3'b100;
    localparam logic [MODE_W-1:0] MODE_REPEAT = 3'b101;

    typedef enum logic [1:0] {
        CH_OFF  = 2'd0,
        CH_WAIT = 2'd1,
        CH_HIGH = 2'd2,
        CH_DONE = 2'd3
    } ch_state_e;

    typedef struct packed {
        logic lead;
        logic trail;
    } match_evt_t;

    function automatic logic is_pulse_mode(logic [MODE_W-1:0] m);
        return (m == MODE_SINGLE) || (m == MODE_REPEAT);
    endfunction

    function automatic logic is_single(logic [MODE_W-1:0] m);
        return m == MODE_SINGLE;
    endfunction

endpackage

// File: rtl/dmp_timer.sv
module dmp_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [TW-1:0] period,
    output logic [TW-1:0] count
);

    logic [TW-1:0] count_q;
    logic [TW-1:0] count_d;
    logic          at_period;

    assign at_period = (count_q == period);

    always_comb begin
        count_d = count_q;
        if (run) begin
            if (at_period) count_d = '0;
            else           count_d = count_q + TW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) count_q <= '0;
        else     count_q <= count_d;
    end

    assign count = count_q;

    // R7
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (run && count == period) |=> (count == '0));

    // R8
    step_up_chk: assert property (@(posedge clk) disable iff (rst)
        (run && count != period) |=> (count == ($past(count) + TW'(1))));

    // R8
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(count));

endmodule

// File: rtl/dmp_match.sv
module dmp_match
    import dmp_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] count,
    input  logic [TW-1:0] lead_val,
    input  logic [TW-1:0] trail_val,
    output match_evt_t    evt
);

    logic [TW-1:0]      ref_val [NUM_CMP];
    logic [NUM_CMP-1:0] eq_now;
    logic [NUM_CMP-1:0] eq_q;
    logic [NUM_CMP-1:0] first_eq;

    assign ref_val[CMP_LEAD]  = lead_val;
    assign ref_val[CMP_TRAIL] = trail_val;

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
        assign eq_now[i]   = (count == ref_val[i]);
        assign first_eq[i] = eq_now[i] & ~eq_q[i];

        always_ff @(posedge clk) begin
            if (rst) eq_q[i] <= 1'b0;
            else     eq_q[i] <= eq_now[i];
        end

        // R9
        single_fire_chk: assert property (@(posedge clk) disable iff (rst)
            first_eq[i] |=> !first_eq[i]);
    end

    assign evt.lead  = first_eq[CMP_LEAD];
    assign evt.trail = first_eq[CMP_TRAIL];

endmodule

// File: rtl/dmp_channel.sv
module dmp_channel
    import dmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_wdata,
    input  match_evt_t        evt,
    input  logic              irq_en,
    input  logic              flag_clr,
    output logic              pulse_out,
    output logic              irq_flag,
    output logic              irq
);

    logic [MODE_W-1:0] mode_q;
    ch_state_e         state_q;
    ch_state_e         state_d;
    logic              flag_q;
    logic              flag_set;

    assign flag_set = (state_q == CH_HIGH) && evt.trail;

    always_comb begin
        state_d = state_q;
        if (mode_wr) begin
            state_d = is_pulse_mode(mode_wdata) ? CH_WAIT : CH_OFF;
        end else begin
            case (state_q)
                CH_WAIT: if (evt.lead) state_d = CH_HIGH;
                CH_HIGH: if (evt.trail) state_d = is_single(mode_q) ? CH_DONE : CH_WAIT;
                default: state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            state_q <= CH_OFF;
            flag_q  <= 1'b0;
        end else begin
            if (mode_wr) mode_q <= mode_wdata;
            state_q <= state_d;
            if (flag_set)      flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
        end
    end

    assign pulse_out = (state_q == CH_HIGH);
    assign irq_flag  = flag_q;
    assign irq       = flag_q & irq_en;

    // R1
    off_mode_low_chk: assert property (@(posedge clk) disable iff (rst)
        !is_pulse_mode(mode_q) |-> !pulse_out);

    // R2
    write_forces_low_chk: assert property (@(posedge clk) disable iff (rst)
        mode_wr |=> !pulse_out);

    // R3
    rise_needs_lead_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_out) |-> $past(evt.lead));

    // R4
    flag_with_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_flag) |-> $fell(pulse_out));

    // R5
    single_stays_done_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == CH_DONE && !mode_wr) |=> (state_q == CH_DONE));

    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_flag && !flag_clr) |=> irq_flag);

endmodule

// File: rtl/dual_match_pulse.sv
module dual_match_pulse
    import dmp_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_TB-1:0] tb_run,
    input  logic [TW-1:0]     tb_period_a,
    input  logic [TW-1:0]     tb_period_b,
    input  logic              tb_sel,
    input  logic [TW-1:0]     cmp_lead,
    input  logic [TW-1:0]     cmp_trail,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              irq_en,
    input  logic              flag_clr,
    output logic              pulse_out,
    output logic              irq_flag,
    output logic              irq,
    output logic [TW-1:0]     count_a,
    output logic [TW-1:0]     count_b
);

    logic [TW-1:0] period_arr [NUM_TB];
    logic [TW-1:0] count_arr  [NUM_TB];
    logic [TW-1:0] watched;
    match_evt_t    evt;

    assign period_arr[0] = tb_period_a;
    assign period_arr[1] = tb_period_b;

    for (genvar t = 0; t < NUM_TB; t++) begin : g_tb
        dmp_timer #(.TW(TW)) u_timer (
            .clk    (clk),
            .rst    (rst),
            .run    (tb_run[t]),
            .period (period_arr[t]),
            .count  (count_arr[t])
        );
    end

    assign watched = tb_sel ? count_arr[1] : count_arr[0];
    assign count_a = count_arr[0];
    assign count_b = count_arr[1];

    dmp_match #(.TW(TW)) u_match (
        .clk       (clk),
        .rst       (rst),
        .count     (watched),
        .lead_val  (cmp_lead),
        .trail_val (cmp_trail),
        .evt       (evt)
    );

    dmp_channel u_channel (
        .clk        (clk),
        .rst        (rst),
        .mode_wr    (mode_wr),
        .mode_wdata (mode_wdata),
        .evt        (evt),
        .irq_en     (irq_en),
        .flag_clr   (flag_clr),
        .pulse_out  (pulse_out),
        .irq_flag   (irq_flag),
        .irq        (irq)
    );

endmodule

// File: tb/dual_match_pulse_tb.sv
module dual_match_pulse_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  tb_run;
    logic [15:0] tb_period_a, tb_period_b, cmp_lead, cmp_trail;
    logic        tb_sel, mode_wr, irq_en, flag_clr;
    logic [2:0]  mode_wdata;
    logic        pulse_out, irq_flag, irq;
    logic [15:0] count_a, count_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    dual_match_pulse u_dut (
        .clk(clk), .rst(rst), .tb_run(tb_run), .tb_period_a(tb_period_a),
        .tb_period_b(tb_period_b), .tb_sel(tb_sel), .cmp_lead(cmp_lead),
        .cmp_trail(cmp_trail), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .irq_en(irq_en), .flag_clr(flag_clr), .pulse_out(pulse_out),
        .irq_flag(irq_flag), .irq(irq), .count_a(count_a), .count_b(count_b)
    );

    typedef struct packed {
        logic [2:0]  mode;
        logic        sel;
        logic [1:0]  run;
        logic [15:0] lead;
        logic [15:0] trail;
        logic [15:0] per;
        logic [7:0]  win;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{3'b100, 1'b0, 2'b01, 16'd3, 16'd7, 16'd10, 8'd40},
        '{3'b101, 1'b0, 2'b01, 16'd2, 16'd5, 16'd8,  8'd40},
        '{3'b101, 1'b1, 2'b10, 16'd4, 16'd6, 16'd6,  8'd30},
        '{3'b101, 1'b1, 2'b01, 16'd2, 16'd4, 16'd9,  8'd30},
        '{3'b011, 1'b0, 2'b11, 16'd2, 16'd4, 16'd9,  8'd30},
        '{3'b100, 1'b1, 2'b11, 16'd1, 16'd2, 16'd3,  8'd20},
        '{3'b101, 1'b0, 2'b11, 16'd5, 16'd6, 16'd6,  8'd30},
        '{3'b000, 1'b0, 2'b11, 16'd1, 16'd3, 16'd5,  8'd20}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    function automatic bit v_active(vec_t v);
        return (v.mode == 3'b100 || v.mode == 3'b101) && v.run[v.sel];
    endfunction

    // R3 R4 R5 R7: high for sample j when (j-1) mod (per+1) lies in [lead, trail-1]
    function automatic bit exp_high(vec_t v, int j);
        int m;
        if (!v_active(v)) return 0;
        if (v.mode == 3'b100 && (j - 1) > int'(v.per)) return 0;
        m = (j - 1) % (int'(v.per) + 1);
        return (m >= int'(v.lead)) && (m <= int'(v.trail) - 1);
    endfunction

    function automatic bit exp_flag(vec_t v, int j);
        return v_active(v) && (j >= int'(v.trail) + 1);
    endfunction

    task automatic do_reset();
        rst = 1; tb_run = 0; mode_wr = 0; mode_wdata = 0; flag_clr = 0;
        irq_en = 1; tb_sel = 0; tb_period_a = 0; tb_period_b = 0;
        cmp_lead = 0; cmp_trail = 0;
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    // Writes the mode at the next edge, then starts the counters at the one after.
    task automatic start(input logic [2:0] m, input logic s, input logic [1:0] r,
                         input int l, input int t, input int p);
        tb_sel = s; cmp_lead = 16'(l); cmp_trail = 16'(t);
        tb_period_a = 16'(p); tb_period_b = 16'(p);
        mode_wr = 1; mode_wdata = m;
        @(negedge clk);
        mode_wr = 0; tb_run = r;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        do_reset();
        // reset state (R1 R10 R11 R8)
        chk(pulse_out == 0, "R1 reset pulse_out", int'(pulse_out), 0);
        chk(irq_flag == 0, "R10 reset irq_flag", int'(irq_flag), 0);
        chk(irq == 0, "R11 reset irq", int'(irq), 0);
        chk(count_a == 0, "R8 reset count_a", int'(count_a), 0);
        chk(count_b == 0, "R8 reset count_b", int'(count_b), 0);

        // table walk: R1 R3 R4 R5 R7 R8 R11
        for (int i = 0; i < NV; i++) begin
            int bad_o;
            int bad_f;
            int first_o;
            vec_t v;
            v = VEC[i];
            bad_o = 0; bad_f = 0; first_o = -1;
            do_reset();
            start(v.mode, v.sel, v.run, int'(v.lead), int'(v.trail), int'(v.per));
            for (int j = 1; j <= int'(v.win); j++) begin
                @(negedge clk);
                if (pulse_out != exp_high(v, j)) begin
                    bad_o++;
                    if (first_o < 0) first_o = j;
                end
                if (irq_flag != exp_flag(v, j)) bad_f++;
            end
            chk(bad_o == 0, $sformatf("R1 R3 R4 R5 R7 R8 vec %0d pulse mismatches (first sample %0d)", i, first_o), bad_o, 0);
            chk(bad_f == 0, $sformatf("R4 R10 vec %0d flag mismatches", i), bad_f, 0);
            chk(irq == exp_flag(v, int'(v.win)), $sformatf("R11 vec %0d irq", i),
                int'(irq), int'(exp_flag(v, int'(v.win))));
            chk(int'(count_a) == (v.run[0] ? int'(v.win) % (int'(v.per) + 1) : 0),
                $sformatf("R7 R8 vec %0d count_a", i), int'(count_a),
                v.run[0] ? int'(v.win) % (int'(v.per) + 1) : 0);
        end

        // R6: re-arm a finished single pulse by rewriting the mode
        begin
            int bad;
            bad = 0;
            do_reset();
            start(3'b100, 0, 2'b01, 3, 5, 9);
            for (int j = 1; j <= 25; j++) @(negedge clk);
            mode_wr = 1; mode_wdata = 3'b100;
            for (int j = 26; j <= 36; j++) begin
                @(negedge clk);
                mode_wr = 0;
                if (pulse_out != (j == 34 || j == 35)) bad++;
            end
            chk(bad == 0, "R6 re-armed single pulse at samples 34..35", bad, 0);
        end

        // R2: a mode write while high drops the output and re-arms
        do_reset();
        start(3'b101, 0, 2'b01, 2, 8, 12);
        for (int j = 1; j <= 4; j++) @(negedge clk);
        chk(pulse_out == 1, "R3 high before forced write", int'(pulse_out), 1);
        mode_wr = 1; mode_wdata = 3'b101;
        @(negedge clk);
        mode_wr = 0;
        chk(pulse_out == 0, "R2 forced low after mode write", int'(pulse_out), 0);
        for (int j = 6; j <= 12; j++) @(negedge clk);
        chk(irq_flag == 0, "R4 no flag when trailing match seen while low", int'(irq_flag), 0);
        for (int j = 13; j <= 16; j++) @(negedge clk);
        chk(pulse_out == 1, "R2 re-armed pulse in next period", int'(pulse_out), 1);

        // R9: count held on the leading value does not re-fire
        begin
            int bad;
            bad = 0;
            do_reset();
            start(3'b101, 0, 2'b01, 3, 6, 20);
            for (int j = 1; j <= 3; j++) @(negedge clk);
            tb_run = 2'b00;
            @(negedge clk);
            chk(pulse_out == 1, "R3 rise from held leading match", int'(pulse_out), 1);
            mode_wr = 1; mode_wdata = 3'b101;
            @(negedge clk);
            mode_wr = 0;
            for (int j = 0; j < 6; j++) begin
                @(negedge clk);
                if (pulse_out != 0) bad++;
            end
            chk(bad == 0, "R9 held count raises no second pulse", bad, 0);
            chk(count_a == 3, "R8 stopped counter holds", int'(count_a), 3);
        end

        // R10 R11: flag gating and clear
        begin
            int bad;
            bad = 0;
            do_reset();
            irq_en = 0;
            start(3'b100, 0, 2'b01, 1, 2, 3);
            for (int j = 1; j <= 4; j++) @(negedge clk);
            chk(irq_flag == 1, "R4 flag set after trailing match", int'(irq_flag), 1);
            chk(irq == 0, "R11 irq gated off", int'(irq), 0);
            irq_en = 1;
            @(negedge clk);
            chk(irq == 1, "R11 irq with enable", int'(irq), 1);
            chk(irq_flag == 1, "R10 flag still set", int'(irq_flag), 1);
            flag_clr = 1;
            @(negedge clk);
            flag_clr = 0;
            chk(irq_flag == 0, "R10 flag cleared", int'(irq_flag), 0);
            for (int j = 0; j < 8; j++) begin
                @(negedge clk);
                if (irq_flag != 0 || pulse_out != 0) bad++;
            end
            chk(bad == 0, "R5 R10 no pulse or flag after single pulse", bad, 0);
        end

        report();
    end

endmodule